// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog that advances on its own always-on tick, so it keeps counting while the main clock is gated off in sleep. It has one 8-bit prescaler that is time-shared with a general-purpose timer. A select input places that prescaler either in front of the timer, where it divides the timer's clock source, or behind the watchdog, where it lengthens the time-out as a postscaler. A 3-bit rate input picks one of eight division taps.

A time-out is handled according to the device state. While the device is awake, a time-out requests a device reset. While the device is asleep, it requests only a wake-up. A status flag records that a time-out happened. Software keeps the watchdog quiet by pulsing the clear strobe. Entering sleep clears the watchdog in the same way.

All logic runs on one always-running clock `clk`. The watchdog tick and the timer source arrive as single-cycle enables on that clock.

Top module: `wdt_shared_prescale`

## Requirements
- R1: After reset `rst_req_o`, `wake_req_o` and `tmr_tick_o` are 0 and `to_flag_o` is 1.
- R2: With `pre_to_wdt_i`=0, a time-out occurs on every 2^BASE_W-th enabled watchdog tick counted since the last clear. The base counter then restarts from zero.
- R3: With `pre_to_wdt_i`=1, a time-out occurs once every 2^BASE_W × 2^(`rate_i`+1) enabled watchdog ticks counted since the last clear. This gives division ratios from 1:2 (`rate_i`=0) up to 1:256 (`rate_i`=7).
- R4: A cycle with `clr_wdt_i` or `sleep_enter_i` high clears the base counter. When `pre_to_wdt_i`=1 it also clears the prescaler. That cycle raises no time-out, and `to_flag_o` is 1 in the following cycle.
- R5: While `wdt_en_i` is 0 the base counter is held at zero and no time-out is raised.
- R6: A time-out while `asleep_i` is 0 gives a one-cycle pulse on `rst_req_o` in the cycle after the final tick, and no pulse on `wake_req_o`.
- R7: A time-out while `asleep_i` is 1 gives a one-cycle pulse on `wake_req_o` only.
- R8: `to_flag_o` goes to 0 together with each time-out pulse. It stays 0 until a clear strobe or a sleep-entry strobe occurs.
- R9: `tmr_tick_o` follows `tmr_src_i` with a one-cycle delay. With `pre_to_wdt_i`=0 it pulses once every 2^(`rate_i`+1) source ticks. With `pre_to_wdt_i`=1 it pulses once for every source tick.
- R10: With `pre_to_wdt_i`=0, the clear and sleep-entry strobes leave the prescaler count untouched, so the timer division continues without disturbance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdt_tick_i | input | 1 | Watchdog oscillator tick enable |
| tmr_src_i | input | 1 | Timer clock source tick enable |
| clr_wdt_i | input | 1 | Clear-watchdog strobe |
| sleep_enter_i | input | 1 | Sleep-entry strobe |
| asleep_i | input | 1 | Device is asleep |
| wdt_en_i | input | 1 | Watchdog enable configuration bit |
| pre_to_wdt_i | input | 1 | 1: prescaler follows the watchdog; 0: prescaler divides the timer source |
| rate_i | input | 3 | Prescaler tap select |
| rst_req_o | output | 1 | Device reset request pulse |
| wake_req_o | output | 1 | Wake-up request pulse |
| to_flag_o | output | 1 | Time-out status, 0 after a time-out |
| tmr_tick_o | output | 1 | Clock tick delivered to the timer |

## Verification
The properties assume that every input is a level or a single-cycle strobe that is synchronous to `clk` and known from the first edge after reset. They also assume that `asleep_i` only changes between edges, so a time-out is classed by the sleep state sampled in the same cycle. The stimulus drives all inputs on the falling edge. The random phase moves the assignment bit, the rate field, the sleep status and the enable bit only rarely, and it pulses the clear strobes sparsely, so that long watchdog periods still run to completion. The directed windows then pin down exact pulse counts for each mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef struct packed {
        logic rst_req;
        logic wake_req;
        logic to_flag;
        logic tmr_tick;
    } wdt_out_t;

    localparam wdt_out_t WDT_OUT_RESET = '{rst_req: 1'b0, wake_req: 1'b0,
                                           to_flag: 1'b1, tmr_tick: 1'b0};

endpackage

// File: rtl/wdt_base_cnt.sv
module wdt_base_cnt #(
    parameter int BASE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    input  logic clr_i,
    output logic ovf_o
);
    typedef struct packed {
        logic [BASE_W-1:0] cnt;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = 1'b0;
        if (clr_i || !en_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            ovf_o    = (st_q.cnt == {BASE_W{1'b1}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              clr_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tap_evt_o
);
    localparam int NTAP = 1 << RATE_W;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [NTAP-1:0]  tap_full;

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        assign tap_full[k] = &st_q.cnt[k:0];
    end

    always_comb begin
        st_d      = st_q;
        tap_evt_o = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            tap_evt_o = tap_full[rate_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout_i,
    input  logic asleep_i,
    input  logic clr_any_i,
    input  logic tmr_evt_i,
    output logic rst_req_o,
    output logic wake_req_o,
    output logic to_flag_o,
    output logic tmr_tick_o
);
    import wdt_pkg::*;

    wdt_out_t out_d, out_q;

    always_comb begin
        out_d          = out_q;
        out_d.rst_req  = timeout_i && !asleep_i;
        out_d.wake_req = timeout_i && asleep_i;
        out_d.tmr_tick = tmr_evt_i;
        if (clr_any_i)      out_d.to_flag = 1'b1;
        else if (timeout_i) out_d.to_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= WDT_OUT_RESET;
        else        out_q <= out_d;
    end

    assign rst_req_o  = out_q.rst_req;
    assign wake_req_o = out_q.wake_req;
    assign to_flag_o  = out_q.to_flag;
    assign tmr_tick_o = out_q.tmr_tick;
endmodule

// File: rtl/wdt_shared_prescale.sv
module wdt_shared_prescale #(
    parameter int BASE_W = 8,
    parameter int PRE_W  = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdt_tick_i,
    input  logic              tmr_src_i,
    input  logic              clr_wdt_i,
    input  logic              sleep_enter_i,
    input  logic              asleep_i,
    input  logic              wdt_en_i,
    input  logic              pre_to_wdt_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              rst_req_o,
    output logic              wake_req_o,
    output logic              to_flag_o,
    output logic              tmr_tick_o
);
    logic clr_any;
    logic base_ovf;
    logic pre_inc;
    logic pre_clr;
    logic tap_evt;
    logic timeout;
    logic tmr_evt;

    assign clr_any = clr_wdt_i || sleep_enter_i;

    wdt_base_cnt #(.BASE_W(BASE_W)) i_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (wdt_tick_i),
        .en_i   (wdt_en_i),
        .clr_i  (clr_any),
        .ovf_o  (base_ovf)
    );

    // Prescaler input and clear follow the assignment bit
    assign pre_inc = pre_to_wdt_i ? base_ovf : tmr_src_i;
    assign pre_clr = pre_to_wdt_i && clr_any;

    wdt_prescaler #(.PRE_W(PRE_W), .RATE_W(RATE_W)) i_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (pre_inc),
        .clr_i     (pre_clr),
        .rate_i    (rate_i),
        .tap_evt_o (tap_evt)
    );

    assign timeout = pre_to_wdt_i ? tap_evt   : base_ovf;
    assign tmr_evt = pre_to_wdt_i ? tmr_src_i : tap_evt;

    wdt_resp i_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .timeout_i  (timeout),
        .asleep_i   (asleep_i),
        .clr_any_i  (clr_any),
        .tmr_evt_i  (tmr_evt),
        .rst_req_o  (rst_req_o),
        .wake_req_o (wake_req_o),
        .to_flag_o  (to_flag_o),
        .tmr_tick_o (tmr_tick_o)
    );
endmodule

// File: rtl/wdt_sva.sv
module wdt_sva (
    input logic clk,
    input logic rst_n,
    input logic tmr_src_i,
    input logic clr_wdt_i,
    input logic sleep_enter_i,
    input logic asleep_i,
    input logic wdt_en_i,
    input logic pre_to_wdt_i,
    input logic rst_req_o,
    input logic wake_req_o,
    input logic to_flag_o,
    input logic tmr_tick_o
);
    a_r4_clear_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_wdt_i || sleep_enter_i) |-> (to_flag_o && !rst_req_o && !wake_req_o));

    a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wdt_en_i) |-> (!rst_req_o && !wake_req_o));

    a_r6_reset_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !$past(asleep_i));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    a_r7_wake_when_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> $past(asleep_i));

    a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && wake_req_o));

    a_r8_flag_falls_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(to_flag_o) |-> (rst_req_o || wake_req_o));

    a_r8_flag_low_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o || wake_req_o) |-> !to_flag_o);

    a_r9_raw_timer_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pre_to_wdt_i) |-> (tmr_tick_o == $past(tmr_src_i)));
endmodule

bind wdt_shared_prescale wdt_sva i_wdt_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .tmr_src_i     (tmr_src_i),
    .clr_wdt_i     (clr_wdt_i),
    .sleep_enter_i (sleep_enter_i),
    .asleep_i      (asleep_i),
    .wdt_en_i      (wdt_en_i),
    .pre_to_wdt_i  (pre_to_wdt_i),
    .rst_req_o     (rst_req_o),
    .wake_req_o    (wake_req_o),
    .to_flag_o     (to_flag_o),
    .tmr_tick_o    (tmr_tick_o)
);

// File: tb/test_wdt_shared_prescale.sv
module test_wdt_shared_prescale;
    localparam int BW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_tick_i = 1'b0, tmr_src_i = 1'b0, clr_wdt_i = 1'b0;
    logic       sleep_enter_i = 1'b0, asleep_i = 1'b0, wdt_en_i = 1'b1;
    logic       pre_to_wdt_i = 1'b0;
    logic [2:0] rate_i = 3'd0;
    logic       rst_req_o, wake_req_o, to_flag_o, tmr_tick_o;

    int total = 0, bad = 0, cycles = 0;
    int nr, nw, nt;

    // reference model state
    int  m_base, m_pre;
    logic e_rst, e_wake, e_flag, e_tmr;

    always #2.5 clk = ~clk;

    wdt_shared_prescale #(.BASE_W(BW)) i_wdt_shared_prescale (.*);

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int div_of(input logic [2:0] r);
        return 2 << r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_pre = 0;
            e_rst = 0; e_wake = 0; e_flag = 1; e_tmr = 0;
        end else begin
            logic to;
            to = 1'b0; e_tmr = 1'b0;
            if (!pre_to_wdt_i && tmr_src_i) begin
                m_pre = (m_pre + 1) % 256;
                if (m_pre % div_of(rate_i) == 0) e_tmr = 1'b1;
            end else if (pre_to_wdt_i && tmr_src_i) begin
                e_tmr = 1'b1;
            end
            if (clr_wdt_i || sleep_enter_i) begin
                m_base = 0;
                if (pre_to_wdt_i) m_pre = 0;
                e_flag = 1'b1;
            end else if (!wdt_en_i) begin
                m_base = 0;
            end else if (wdt_tick_i) begin
                m_base = m_base + 1;
                if (m_base == (1 << BW)) begin
                    m_base = 0;
                    if (!pre_to_wdt_i) to = 1'b1;
                    else begin
                        m_pre = (m_pre + 1) % 256;
                        if (m_pre % div_of(rate_i) == 0) to = 1'b1;
                    end
                end
            end
            e_rst  = to && !asleep_i;
            e_wake = to && asleep_i;
            if (to) e_flag = 1'b0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R6 rst_req", rst_req_o, e_rst);
            check("R7 wake_req", wake_req_o, e_wake);
            check("R8 to_flag", to_flag_o, e_flag);
            check("R9 tmr_tick", tmr_tick_o, e_tmr);
        end
        if (cycles > 150000) begin
            bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic window(input int n);
        nr = 0; nw = 0; nt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req_o)  nr++;
            if (wake_req_o) nw++;
            if (tmr_tick_o) nt++;
        end
    endtask

    task automatic strobe_clear();
        @(negedge clk); clr_wdt_i = 1'b1; wdt_tick_i = 1'b0; tmr_src_i = 1'b0;
        @(negedge clk); clr_wdt_i = 1'b0;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1357);
        repeat (3) @(negedge clk);
        check("R1 rst_req at reset", rst_req_o, 0);
        check("R1 wake_req at reset", wake_req_o, 0);
        check("R1 to_flag at reset", to_flag_o, 1);
        check("R1 tmr_tick at reset", tmr_tick_o, 0);
        rst_n = 1'b1;

        // R2: timer-assigned, base overflow alone
        pre_to_wdt_i = 0; strobe_clear();
        wdt_tick_i = 1; window(64); wdt_tick_i = 0;
        check("R2 timeouts in 64 ticks", nr, 4);
        check("R8 flag low after timeout", to_flag_o, 0);
        window(5);
        check("R8 flag stays low", to_flag_o, 0);
        strobe_clear();
        check("R8 flag set by clear", to_flag_o, 1);

        // R3: watchdog-assigned postscaler
        pre_to_wdt_i = 1; rate_i = 0; strobe_clear();
        wdt_tick_i = 1; window(64); wdt_tick_i = 0;
        check("R3 rate0 timeouts", nr, 2);
        rate_i = 2; strobe_clear();
        wdt_tick_i = 1; window(255); wdt_tick_i = 0;
        check("R3 rate2 before period", nr, 1);
        wdt_tick_i = 1; window(1); wdt_tick_i = 0;
        check("R3 rate2 at period", nr, 1);

        // R7: asleep -> wake only
        asleep_i = 1; rate_i = 0; strobe_clear();
        wdt_tick_i = 1; window(64); wdt_tick_i = 0;
        check("R7 wake count", nw, 2);
        check("R7 no reset while asleep", nr, 0);
        @(negedge clk); sleep_enter_i = 1;
        @(negedge clk); sleep_enter_i = 0;
        check("R4 sleep entry sets flag", to_flag_o, 1);
        asleep_i = 0;

        // R5: disabled
        wdt_en_i = 0; wdt_tick_i = 1; window(200); wdt_tick_i = 0;
        check("R5 no timeout disabled", nr + nw, 0);
        wdt_en_i = 1;

        // R4: periodic clears keep it quiet
        pre_to_wdt_i = 1; rate_i = 0;
        for (int k = 0; k < 20; k++) begin
            strobe_clear(); wdt_tick_i = 1; window(25); wdt_tick_i = 0;
            check("R4 cleared watchdog silent", nr, 0);
        end

        // R9: timer clock paths
        pre_to_wdt_i = 0; rate_i = 1;
        tmr_src_i = 1; window(40); tmr_src_i = 0;
        check("R9 prescaled timer ticks", nt, 10);
        pre_to_wdt_i = 1;
        tmr_src_i = 1; window(40); tmr_src_i = 0;
        check("R9 raw timer ticks", nt, 40);

        // R10: clears do not disturb timer prescaler
        pre_to_wdt_i = 0; rate_i = 1; nt = 0;
        begin
            int cnt_t;
            cnt_t = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (tmr_tick_o) cnt_t++;
                tmr_src_i = 1; clr_wdt_i = (k % 3 == 0);
            end
            @(negedge clk); if (tmr_tick_o) cnt_t++;
            tmr_src_i = 0; clr_wdt_i = 0;
            check("R10 timer division unaffected", cnt_t, 10);
        end

        // random phase, checked per cycle against the model
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            wdt_tick_i    = ($urandom % 4) != 0;
            tmr_src_i     = ($urandom % 2) != 0;
            clr_wdt_i     = ($urandom % 300) == 0;
            sleep_enter_i = ($urandom % 700) == 0;
            if ($urandom % 500 == 0) asleep_i = ~asleep_i;
            if ($urandom % 900 == 0) pre_to_wdt_i = ~pre_to_wdt_i;
            if ($urandom % 900 == 0) rate_i = 3'($urandom % 3);
            if ($urandom % 1500 == 0) wdt_en_i = ~wdt_en_i;
        end
        @(negedge clk);
        wdt_tick_i = 0; tmr_src_i = 0; clr_wdt_i = 0; sleep_enter_i = 0;
        repeat (2) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule